// File: doc/BRIEF.md
# Sleep State Controller with Button Override

This block sequences a platform between its working state and three low-power states: a light processor sleep (S1), suspend-to-RAM (S3) and soft-off (S5). Software requests a state by pulsing a request strobe with a target code. A short press of the debounced power button does the same thing, using the code that software has placed on the target input beforehand. Every entry into a low-power state goes through a processor stop-clock phase of programmable length before the deeper control output is asserted. From S1 or S3, a wake event or a short press brings the system back, and the outputs are released in the reverse of their entry order.

A hold timer measures how long the button stays pressed, in prescaled ticks. If the button is held continuously up to the threshold, the block goes to soft-off at once, from any state and from any point in the entry sequence, and the stop-clock phase is skipped. The S2 code, like any other code outside the supported set, is ignored. A 2-bit status output reports the current state. A bank of clock-enable outputs is gated in S3 and S5. Bit 0 of that bank drives the always-on real-time clock and is never gated.

Top module: `sleep_seq_top`

## Requirements
- R1: After a synchronous active-low reset: state_o = 00, stpclk_o = 0, cpu_sleep_o = 0, str_n_o = 1, soft_off_n_o = 1, and every clk_en_o bit is 1.
- R2: In S0, a request whose code on target_i is 1, 3 or 5 selects S1, S3 or S5. Every other code (0, 2, 4, 6, 7) is ignored: stpclk_o stays 0 and state_o stays 00.
- R3: An entry that software invokes or a short press invokes first drives stpclk_o = 1 with cpu_sleep_o = 0, str_n_o = 1 and soft_off_n_o = 1 for exactly C2_MIN cycles, with state_o = 00. The target outputs appear in the next cycle.
- R4: In S1: state_o = 01, stpclk_o = 1, cpu_sleep_o = 1, str_n_o = 1, soft_off_n_o = 1, and all clk_en_o bits are 1.
- R5: In S3: state_o = 10, stpclk_o = 1, cpu_sleep_o = 1, str_n_o = 0, soft_off_n_o = 1, and only clk_en_o[0] is 1.
- R6: In S5: state_o = 11, stpclk_o = 0, cpu_sleep_o = 0, str_n_o = 0, soft_off_n_o = 0, and only clk_en_o[0] is 1.
- R7: When btn_i is sampled high on HOLD_TICKS*PRESC consecutive edges, state_o = 11 in the cycle after the next edge. This applies from any state, the stop-clock phase included.
- R8: Releasing the button before the threshold clears the hold count, so a later press must be held for the full threshold again.
- R9: In S0, a short press (a release before the threshold) acts on the edge after the release as a request with the code then present on target_i.
- R10: In S1 or S3, wake_i or a short press gives one cycle with stpclk_o = 1, cpu_sleep_o = 0, str_n_o = 1 and state_o = 00, then the S0 outputs.
- R11: S5 is left only by a short press, which goes straight to S0 two edges after the release. wake_i and software requests have no effect in S5, and the release that ends a long hold is not counted as a short press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_i | input | 1 | Debounced power button, 1 = pressed |
| sw_req_i | input | 1 | One-cycle software sleep request strobe |
| target_i | input | 3 | Target state number (1, 3 or 5 are legal) |
| wake_i | input | 1 | Wake event, acts in S1 and S3 |
| stpclk_o | output | 1 | Processor stop-clock request, active high |
| cpu_sleep_o | output | 1 | Processor sleep request, active high |
| str_n_o | output | 1 | Suspend-to-RAM power-plane control, active low |
| soft_off_n_o | output | 1 | Soft-off control, active low |
| clk_en_o | output | NUM_CLK | Clock enables, bit 0 is the real-time clock |
| state_o | output | 2 | Current state: 00 S0, 01 S1, 10 S3, 11 S5 |

## Verification
The hardest case to reach from the ports is a long-hold override that arrives while the stop-clock phase is under way. Button presses only take effect on release or at the threshold, and the stop-clock phase lasts a few cycles. To hit it, the bench holds the button and then issues a software request exactly two cycles before the threshold. It then checks that stop-clock is still showing one cycle later and that soft-off follows on the next edge. A second directed case releases the button one cycle short of the threshold and presses again, to show that the hold count starts from zero. Random request codes, alternating wake and short-press exits, cover the rest of the state space against a bench model of the output table.

// File: rtl/sleep_pkg.sv
// Shared types for the sleep-state sequencer.
// Assumes: state codes on the status output are fixed by the platform.
package sleep_pkg;

    // Internal sequencer states. C2 and EXIT are transient steps.
    typedef enum logic [2:0] {
        ST_S0   = 3'd0,
        ST_C2   = 3'd1,
        ST_S1   = 3'd2,
        ST_S3   = 3'd3,
        ST_S5   = 3'd4,
        ST_EXIT = 3'd5
    } seq_st_t;

    localparam logic [1:0] CODE_S0 = 2'b00;
    localparam logic [1:0] CODE_S1 = 2'b01;
    localparam logic [1:0] CODE_S3 = 2'b10;
    localparam logic [1:0] CODE_S5 = 2'b11;

    // Drive levels of the control outputs for one state.
    typedef struct packed {
        logic       stp;
        logic       slp;
        logic       str_n;
        logic       off_n;
        logic       gate;
        logic [1:0] code;
    } pwr_out_t;

endpackage

// File: rtl/btn_hold_timer.sv
// Measures a continuous button hold in prescaled ticks.
// It emits a one-cycle long pulse when the hold reaches HOLD_TICKS ticks, and a
// one-cycle short pulse on a release that comes before that.
// Assumes: btn_i is already debounced and synchronous to clk.
module btn_hold_timer #(
    parameter int PRESC      = 8,
    parameter int HOLD_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_i,
    output logic short_o,
    output logic long_o
);
    localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
    localparam int HW = $clog2(HOLD_TICKS + 1);

    logic [PW-1:0] pre_q;
    logic [HW-1:0] hold_q;
    logic          fired_q;
    logic          btn_q;
    logic          short_q;
    logic          long_q;

    // Prescale the hold, count ticks and flag the threshold and short releases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            hold_q  <= '0;
            fired_q <= 1'b0;
            btn_q   <= 1'b0;
            short_q <= 1'b0;
            long_q  <= 1'b0;
        end else begin
            btn_q   <= btn_i;
            short_q <= !btn_i && btn_q && !fired_q;
            long_q  <= 1'b0;
            if (!btn_i) begin
                pre_q   <= '0;
                hold_q  <= '0;
                fired_q <= 1'b0;
            end else if (!fired_q) begin
                if (pre_q == PW'(PRESC - 1)) begin
                    pre_q  <= '0;
                    hold_q <= hold_q + 1'b1;
                    if (hold_q == HW'(HOLD_TICKS - 1)) begin
                        fired_q <= 1'b1;
                        long_q  <= 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    assign short_o = short_q;
    assign long_o  = long_q;

    // R8: a release always leaves the hold count at zero.
    a_r8_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_i |=> (hold_q == '0) && !fired_q);

    // R11: a release after the threshold is never a short press.
    a_r11_no_short_after_long: assert property (@(posedge clk) disable iff (!rst_n)
        (fired_q && !btn_i) |=> !short_o);

endmodule

// File: rtl/dwell_timer.sv
// Counts the cycles spent in the stop-clock step and reports when the minimum
// dwell is reached.
// Assumes: run_i stays high for the whole step and drops when the step ends.
module dwell_timer #(
    parameter int C2_MIN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = (C2_MIN > 1) ? $clog2(C2_MIN) : 1;

    logic [CW-1:0] cnt_q;

    // Count while running, hold at the limit, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (!done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == CW'(C2_MIN - 1));

endmodule

// File: rtl/sleep_out_decode.sv
// Maps a sequencer state onto the control outputs and the status code.
// Assumes: NUM_CLK >= 2, and bit 0 of the clock enables is the always-on RTC.
module sleep_out_decode
    import sleep_pkg::*;
#(
    parameter int NUM_CLK = 4
) (
    input  seq_st_t            st_i,
    output logic               stp_o,
    output logic               slp_o,
    output logic               str_n_o,
    output logic               off_n_o,
    output logic [NUM_CLK-1:0] clk_en_o,
    output logic [1:0]         code_o
);
    pwr_out_t po;

    // Output table per state.
    always_comb begin
        case (st_i)
            ST_C2:   po = '{stp: 1'b1, slp: 1'b0, str_n: 1'b1, off_n: 1'b1, gate: 1'b0, code: CODE_S0};
            ST_S1:   po = '{stp: 1'b1, slp: 1'b1, str_n: 1'b1, off_n: 1'b1, gate: 1'b0, code: CODE_S1};
            ST_S3:   po = '{stp: 1'b1, slp: 1'b1, str_n: 1'b0, off_n: 1'b1, gate: 1'b1, code: CODE_S3};
            ST_S5:   po = '{stp: 1'b0, slp: 1'b0, str_n: 1'b0, off_n: 1'b0, gate: 1'b1, code: CODE_S5};
            ST_EXIT: po = '{stp: 1'b1, slp: 1'b0, str_n: 1'b1, off_n: 1'b1, gate: 1'b0, code: CODE_S0};
            default: po = '{stp: 1'b0, slp: 1'b0, str_n: 1'b1, off_n: 1'b1, gate: 1'b0, code: CODE_S0};
        endcase
    end

    assign stp_o   = po.stp;
    assign slp_o   = po.slp;
    assign str_n_o = po.str_n;
    assign off_n_o = po.off_n;
    assign code_o  = po.code;

    // Gate every clock enable except the RTC one.
    genvar g;
    generate
        for (g = 0; g < NUM_CLK; g++) begin : g_clk
            if (g == 0) begin : g_rtc
                assign clk_en_o[g] = 1'b1;
            end else begin : g_gated
                assign clk_en_o[g] = !po.gate;
            end
        end
    endgenerate

endmodule

// File: rtl/sleep_seq_top.sv
// Platform sleep-state sequencer for S0, S1, S3 and S5.
// Graceful entry passes through a stop-clock dwell, and a long button hold
// forces soft-off. Wake from S1 or S3 releases the outputs in reverse order.
// Assumes: btn_i is debounced, all inputs are synchronous to clk, C2_MIN >= 1.
module sleep_seq_top
    import sleep_pkg::*;
#(
    parameter int PRESC      = 8,
    parameter int HOLD_TICKS = 16,
    parameter int C2_MIN     = 5,
    parameter int NUM_CLK    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn_i,
    input  logic               sw_req_i,
    input  logic [2:0]         target_i,
    input  logic               wake_i,
    output logic               stpclk_o,
    output logic               cpu_sleep_o,
    output logic               str_n_o,
    output logic               soft_off_n_o,
    output logic [NUM_CLK-1:0] clk_en_o,
    output logic [1:0]         state_o
);
    seq_st_t st_q, st_d;
    seq_st_t tgt_q, tgt_d;
    seq_st_t req_tgt;
    logic    req_ok;
    logic    short_w, long_w, c2_done;

    btn_hold_timer #(.PRESC(PRESC), .HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_i   (btn_i),
        .short_o (short_w),
        .long_o  (long_w)
    );

    dwell_timer #(.C2_MIN(C2_MIN)) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (st_q == ST_C2),
        .done_o (c2_done)
    );

    // Decode the requested target number; only 1, 3 and 5 are accepted.
    always_comb begin
        req_ok  = 1'b1;
        req_tgt = ST_S0;
        case (target_i)
            3'd1:    req_tgt = ST_S1;
            3'd3:    req_tgt = ST_S3;
            3'd5:    req_tgt = ST_S5;
            default: req_ok  = 1'b0;
        endcase
    end

    // Next-state logic; a long hold overrides every other event.
    always_comb begin
        st_d  = st_q;
        tgt_d = tgt_q;
        if (long_w) begin
            st_d = ST_S5;
        end else begin
            case (st_q)
                ST_S0: if ((sw_req_i || short_w) && req_ok) begin
                    st_d  = ST_C2;
                    tgt_d = req_tgt;
                end
                ST_C2:        if (c2_done) st_d = tgt_q;
                ST_S1, ST_S3: if (wake_i || short_w) st_d = ST_EXIT;
                ST_EXIT:      st_d = ST_S0;
                ST_S5:        if (short_w) st_d = ST_S0;
                default:      st_d = ST_S0;
            endcase
        end
    end

    // State and latched target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_S0;
            tgt_q <= ST_S0;
        end else begin
            st_q  <= st_d;
            tgt_q <= tgt_d;
        end
    end

    sleep_out_decode #(.NUM_CLK(NUM_CLK)) u_dec (
        .st_i     (st_q),
        .stp_o    (stpclk_o),
        .slp_o    (cpu_sleep_o),
        .str_n_o  (str_n_o),
        .off_n_o  (soft_off_n_o),
        .clk_en_o (clk_en_o),
        .code_o   (state_o)
    );

    // R3: processor sleep only rises after a stop-clock cycle.
    a_r3_c2_before_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_sleep_o) |-> $past(stpclk_o));

    // R10: on a wake, sleep drops while stop-clock is still held.
    a_r10_release_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_sleep_o) && soft_off_n_o) |-> stpclk_o);

    // R7: the hold threshold pulse always lands in S5.
    a_r7_override: assert property (@(posedge clk) disable iff (!rst_n)
        long_w |=> (state_o == CODE_S5));

    // R2: an unsupported code leaves S0 untouched.
    a_r2_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_S0 && sw_req_i && !req_ok && !long_w && !short_w) |=> (st_q == ST_S0));

    // R5: suspend-to-RAM gates every clock except the RTC.
    a_r5_clk_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !str_n_o |-> (clk_en_o[NUM_CLK-1:1] == '0));

    // R11: only a short press leaves S5.
    a_r11_s5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == CODE_S5 && !short_w) |=> (state_o == CODE_S5));

endmodule

// File: tb/tb_sleep_seq_top.sv
module tb_sleep_seq_top;
    localparam int CLK_PERIOD = 10;
    localparam int PRESC      = 8;
    localparam int HOLD_TICKS = 16;
    localparam int C2_MIN     = 5;
    localparam int NUM_CLK    = 4;
    localparam int HOLD_CYC   = HOLD_TICKS * PRESC;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               btn_i = 1'b0;
    logic               sw_req_i = 1'b0;
    logic [2:0]         target_i = 3'd0;
    logic               wake_i = 1'b0;
    logic               stpclk_o, cpu_sleep_o, str_n_o, soft_off_n_o;
    logic [NUM_CLK-1:0] clk_en_o;
    logic [1:0]         state_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_seq_top #(.PRESC(PRESC), .HOLD_TICKS(HOLD_TICKS), .C2_MIN(C2_MIN), .NUM_CLK(NUM_CLK)) dut (
        .clk(clk), .rst_n(rst_n), .btn_i(btn_i), .sw_req_i(sw_req_i), .target_i(target_i),
        .wake_i(wake_i), .stpclk_o(stpclk_o), .cpu_sleep_o(cpu_sleep_o), .str_n_o(str_n_o),
        .soft_off_n_o(soft_off_n_o), .clk_en_o(clk_en_o), .state_o(state_o)
    );

    // Expected {stpclk, sleep, str_n, soft_off_n} for a status code.
    function automatic logic [3:0] exp_outs(input logic [1:0] code);
        case (code)
            2'b00:   return 4'b0011;
            2'b01:   return 4'b1111;
            2'b10:   return 4'b1101;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [NUM_CLK-1:0] exp_clk(input logic [1:0] code);
        return (code[1]) ? NUM_CLK'(1) : {NUM_CLK{1'b1}};
    endfunction

    // Returns {legal, status code} for a target number.
    function automatic logic [2:0] exp_target(input logic [2:0] num);
        case (num)
            3'd1:    return 3'b101;
            3'd3:    return 3'b110;
            3'd5:    return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input logic [1:0] code);
        chk({tag, " state"}, 32'(state_o), 32'(code));
        chk({tag, " outs"}, 32'({stpclk_o, cpu_sleep_o, str_n_o, soft_off_n_o}), 32'(exp_outs(code)));
        chk({tag, " clk_en"}, 32'(clk_en_o), 32'(exp_clk(code)));
    endtask

    task automatic chk_c2(input string tag);
        chk({tag, " c2 outs"}, 32'({stpclk_o, cpu_sleep_o, str_n_o, soft_off_n_o, state_o}), 32'(6'b101100));
    endtask

    // Issue a software request and check the graceful sequence.
    task automatic req_enter(input logic [2:0] num);
        logic [2:0] e;
        e = exp_target(num);
        target_i = num;
        sw_req_i = 1'b1;
        @(negedge clk);
        sw_req_i = 1'b0;
        if (e[2]) begin
            chk_c2("R3 first");
            repeat (C2_MIN - 1) @(negedge clk);
            chk_c2("R3 last");
            @(negedge clk);
            chk_state("R4/R5/R6 target", e[1:0]);
        end else begin
            for (int i = 0; i < C2_MIN + 2; i++) begin
                chk_state("R2 ignored", 2'b00);
                @(negedge clk);
            end
        end
    endtask

    task automatic press(input int n);
        btn_i = 1'b1;
        repeat (n) @(negedge clk);
        btn_i = 1'b0;
    endtask

    task automatic check_exit();
        chk("R10 exit outs", 32'({stpclk_o, cpu_sleep_o, str_n_o, soft_off_n_o, state_o}), 32'(6'b101100));
        @(negedge clk);
        chk_state("R10 back", 2'b00);
    endtask

    task automatic leave(input logic [1:0] code, input bit use_btn);
        if (code == 2'b11) begin
            press(3);
            repeat (2) @(negedge clk);
            chk_state("R11 short exit", 2'b00);
        end else if (use_btn) begin
            press(3);
            repeat (2) @(negedge clk);
            check_exit();
        end else begin
            wake_i = 1'b1;
            @(negedge clk);
            wake_i = 1'b0;
            check_exit();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1 reset", 2'b00);

        req_enter(3'd1);
        leave(2'b01, 1'b0);
        req_enter(3'd3);
        leave(2'b10, 1'b0);
        req_enter(3'd2);

        // R11: wake and requests do nothing in S5.
        req_enter(3'd5);
        wake_i = 1'b1;
        @(negedge clk);
        wake_i = 1'b0;
        target_i = 3'd1;
        sw_req_i = 1'b1;
        @(negedge clk);
        sw_req_i = 1'b0;
        repeat (3) @(negedge clk);
        chk_state("R11 stays S5", 2'b11);
        leave(2'b11, 1'b0);

        // R9: a short press picks the preselected target.
        target_i = 3'd3;
        press(4);
        repeat (2) @(negedge clk);
        chk_c2("R9 short press");
        repeat (C2_MIN) @(negedge clk);
        chk_state("R9 into S3", 2'b10);
        leave(2'b10, 1'b1);

        // R8: release one cycle short, then a fresh full hold.
        target_i = 3'd0;
        press(HOLD_CYC - 1);
        @(negedge clk);
        btn_i = 1'b1;
        repeat (HOLD_CYC) @(negedge clk);
        chk("R8 not early", 32'(state_o), 32'(2'b00));
        @(negedge clk);
        chk_state("R7 R8 full hold", 2'b11);
        btn_i = 1'b0;
        repeat (4) @(negedge clk);
        chk_state("R11 release after long", 2'b11);
        leave(2'b11, 1'b0);

        // R7: override lands during the stop-clock dwell.
        btn_i = 1'b1;
        repeat (HOLD_CYC - 2) @(negedge clk);
        target_i = 3'd3;
        sw_req_i = 1'b1;
        @(negedge clk);
        sw_req_i = 1'b0;
        @(negedge clk);
        chk_c2("R7 in c2");
        @(negedge clk);
        chk_state("R7 override in c2", 2'b11);
        btn_i = 1'b0;
        repeat (2) @(negedge clk);
        leave(2'b11, 1'b0);

        // R7: override from S1.
        req_enter(3'd1);
        btn_i = 1'b1;
        repeat (HOLD_CYC) @(negedge clk);
        chk_state("R7 before threshold", 2'b01);
        @(negedge clk);
        chk_state("R7 from S1", 2'b11);
        btn_i = 1'b0;
        repeat (2) @(negedge clk);
        leave(2'b11, 1'b0);

        // Random request codes with alternating exits.
        for (int k = 0; k < 24; k++) begin
            logic [2:0] num;
            logic [2:0] e;
            num = 3'($urandom_range(0, 7));
            e = exp_target(num);
            req_enter(num);
            if (e[2]) leave(e[1:0], 1'($urandom_range(0, 1)));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule